// File: doc/BRIEF.md
# Command bus timing guard

This block sits between a command scheduler and the command bus of one DRAM channel that carries several ranks. In every cycle the scheduler offers one candidate command, given as a type and a rank index. The guard answers in the same cycle whether that command may be issued now.

A yes means the command is granted. A granted command updates the guard's history at the next clock edge. A blocked command leaves the history untouched, and the scheduler can offer it again or offer something else.

The guard tracks the spacing between column commands (reads and writes). This covers column-to-column spacing, rank switching and read/write turnaround on the shared data bus, and the turnaround is computed differently for the same rank and for different ranks. The guard also enforces a sliding four-activate window for each rank.

Spacing is counted in cycles between grants. A command granted in cycle t with a required gap g may next be followed in cycle t+g. All delays and the rank count are parameters.

Top module: `cmd_bus_guard`

## Requirements
- R1: `grant` is high only while `cmd_valid` is high. A valid command of type 2'b11 (bus commands that are not guarded) is always granted.
- R2: After reset there is no history. The first read (type 2'b01), the first write (type 2'b10) and the first activate (type 2'b00) to any rank are granted at once.
- R3: A column command after a column command of the same type to the same rank is granted only from 4 cycles after the earlier grant (tCCD).
- R4: A column command after one of the same type to a different rank needs tBUS+tRTRS = 5 cycles.
- R5: A write after a read, whichever rank either targets, needs tRL+tBUS+tRTRS−tWL = 7 cycles.
- R6: A read after a write to the same rank needs tWL+tBUS+tWTR = 16 cycles.
- R7: A read after a write to a different rank needs tWL+tBUS+tRTRS−tRL = 3 cycles. This is raised to tCCD, so 4 cycles are required.
- R8: At most four activates go to one rank within any 20-cycle window. A fifth activate is blocked until 20 cycles after the oldest of the four.
- R9: The activate window is kept separately for each rank. Activates to one rank do not block activates to another rank.
- R10: Activates, commands of type 2'b11 and blocked candidates do not change the column history. The required column spacing is still counted from the last granted column command.
- R11: The count of cycles since the last column command saturates instead of wrapping. After a long idle period any column command is granted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A candidate command is offered this cycle |
| cmd_type | input | 2 | 00 activate, 01 read, 10 write, 11 not guarded |
| cmd_rank | input | RANK_W | Target rank of the candidate |
| grant | output | 1 | The candidate may be issued in this cycle |

## Verification
`grant` is combinational, so each answer is due in the same cycle as the candidate that produced it. A grant changes the history only at the next rising edge. A spacing of g cycles is therefore measured as g driven cycles after the granting cycle.

The driver applies each candidate just after a rising edge and queues the expected answer. The monitor compares at the following falling edge. Every limit is probed one cycle before it is reached, where the candidate must be blocked, and then exactly at the limit, where it must be granted.

// File: rtl/cmd_bus_guard.sv
module cmd_bus_guard #(
  parameter int NUM_RANKS = 2,
  parameter int T_BUS     = 4,
  parameter int T_RTRS    = 1,
  parameter int T_RL      = 9,
  parameter int T_WL      = 7,
  parameter int T_WTR     = 5,
  parameter int T_CCD     = 4,
  parameter int T_FAW     = 20,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_type,
  input  logic [RANK_W-1:0] cmd_rank,
  output logic              grant
);

  localparam logic [1:0] C_ACT = 2'b00;
  localparam logic [1:0] C_RD  = 2'b01;
  localparam logic [1:0] C_WR  = 2'b10;

  localparam int RAW_RANK = T_BUS + T_RTRS;
  localparam int RAW_RW   = T_RL + T_BUS + T_RTRS - T_WL;
  localparam int RAW_WRS  = T_WL + T_BUS + T_WTR;
  localparam int RAW_WRD  = T_WL + T_BUS + T_RTRS - T_RL;
  localparam int G_SAME   = T_CCD;
  localparam int G_RANK   = (RAW_RANK > T_CCD) ? RAW_RANK : T_CCD;
  localparam int G_RW     = (RAW_RW   > T_CCD) ? RAW_RW   : T_CCD;
  localparam int G_WRS    = (RAW_WRS  > T_CCD) ? RAW_WRS  : T_CCD;
  localparam int G_WRD    = (RAW_WRD  > T_CCD) ? RAW_WRD  : T_CCD;
  localparam int G_M1     = (G_RANK > G_RW)  ? G_RANK : G_RW;
  localparam int G_M2     = (G_WRS  > G_WRD) ? G_WRS  : G_WRD;
  localparam int G_MAX    = (G_M1 > G_M2) ? G_M1 : G_M2;
  localparam int CNT_W    = $clog2(G_MAX + 1);
  localparam int AGE_W    = $clog2(T_FAW + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;
  localparam logic [AGE_W-1:0] AGE_OLD = AGE_W'(T_FAW);

  logic              have_col;
  logic              last_wr;
  logic [RANK_W-1:0] last_rank;
  logic [CNT_W-1:0]  since_col;
  logic [CNT_W-1:0]  need_gap;
  logic              is_col, col_ok;
  logic [NUM_RANKS-1:0] faw_ok;

  assign is_col = (cmd_type == C_RD) || (cmd_type == C_WR);

  always_comb begin
    logic this_wr, same_rank;
    this_wr   = (cmd_type == C_WR);
    same_rank = (cmd_rank == last_rank);
    if (this_wr == last_wr)
      need_gap = same_rank ? CNT_W'(G_SAME) : CNT_W'(G_RANK);
    else if (this_wr)
      need_gap = CNT_W'(G_RW);
    else
      need_gap = same_rank ? CNT_W'(G_WRS) : CNT_W'(G_WRD);
  end

  assign col_ok = !have_col || (since_col >= need_gap);

  always_comb begin
    if (!cmd_valid)           grant = 1'b0;
    else if (cmd_type == C_ACT) grant = faw_ok[cmd_rank];
    else if (is_col)          grant = col_ok;
    else                      grant = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_col  <= 1'b0;
      last_wr   <= 1'b0;
      last_rank <= '0;
      since_col <= CNT_SAT;
    end else if (grant && is_col) begin
      have_col  <= 1'b1;
      last_wr   <= (cmd_type == C_WR);
      last_rank <= cmd_rank;
      since_col <= CNT_W'(1);
    end else if (since_col != CNT_SAT) begin
      since_col <= since_col + 1'b1;
    end
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic [AGE_W-1:0] age [4];
    logic             hit;
    assign hit       = grant && (cmd_type == C_ACT) && (cmd_rank == RANK_W'(r));
    assign faw_ok[r] = (age[3] >= AGE_OLD);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < 4; i++) age[i] <= AGE_OLD;
      end else begin
        for (int i = 0; i < 4; i++) begin
          if (hit && i == 0)
            age[i] <= AGE_W'(1);
          else if (hit)
            age[i] <= (age[i-1] >= AGE_OLD) ? AGE_OLD : age[i-1] + 1'b1;
          else
            age[i] <= (age[i] >= AGE_OLD) ? AGE_OLD : age[i] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cmd_bus_guard_chk.sv
module cmd_bus_guard_chk #(
  parameter int T_BUS  = 4,
  parameter int T_RTRS = 1,
  parameter int T_RL   = 9,
  parameter int T_WL   = 7,
  parameter int T_WTR  = 5,
  parameter int T_CCD  = 4,
  parameter int RANK_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_type,
  input logic [RANK_W-1:0] cmd_rank,
  input logic              grant
);

  logic              seen;
  logic              prev_wr;
  logic [RANK_W-1:0] prev_rank;
  logic [7:0]        gap;
  logic              col_g;

  assign col_g = grant && (cmd_type == 2'b01 || cmd_type == 2'b10);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0; prev_wr <= 1'b0; prev_rank <= '0; gap <= 8'd0;
    end else if (col_g) begin
      seen <= 1'b1; prev_wr <= cmd_type[1]; prev_rank <= cmd_rank; gap <= 8'd1;
    end else if (gap != 8'hff) begin
      gap <= gap + 8'd1;
    end
  end

  a_r1_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> cmd_valid);
  a_r1_free_type: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == 2'b11) |-> grant);
  a_r3_ccd: assert property (@(posedge clk) disable iff (!rst_n)
    (col_g && seen) |-> (int'(gap) >= T_CCD));
  a_r4_rank_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (col_g && seen && cmd_type[1] == prev_wr && cmd_rank != prev_rank)
      |-> (int'(gap) >= T_BUS + T_RTRS));
  a_r5_rd_to_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (col_g && seen && cmd_type == 2'b10 && !prev_wr)
      |-> (int'(gap) >= T_RL + T_BUS + T_RTRS - T_WL));
  a_r6_wr_to_rd_same: assert property (@(posedge clk) disable iff (!rst_n)
    (col_g && seen && cmd_type == 2'b01 && prev_wr && cmd_rank == prev_rank)
      |-> (int'(gap) >= T_WL + T_BUS + T_WTR));
  a_r7_wr_to_rd_other: assert property (@(posedge clk) disable iff (!rst_n)
    (col_g && seen && cmd_type == 2'b01 && prev_wr && cmd_rank != prev_rank)
      |-> (int'(gap) >= T_WL + T_BUS + T_RTRS - T_RL));

endmodule

bind cmd_bus_guard cmd_bus_guard_chk #(
  .T_BUS(T_BUS), .T_RTRS(T_RTRS), .T_RL(T_RL), .T_WL(T_WL),
  .T_WTR(T_WTR), .T_CCD(T_CCD), .RANK_W(RANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
  .cmd_type(cmd_type), .cmd_rank(cmd_rank), .grant(grant)
);

// File: tb/sim_cmd_bus_guard.sv
module sim_cmd_bus_guard;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_type = 2'b11;
  logic [0:0] cmd_rank = 1'b0;
  logic       grant;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit exp_q[$];
  string tag_q[$];
  bit done = 0;

  cmd_bus_guard u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_type(cmd_type), .cmd_rank(cmd_rank), .grant(grant)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (grant !== e) begin
        errors++;
        $display("FAIL %s: grant=%0b expected=%0b", t, grant, e);
      end
    end
  end

  task automatic step(input bit v, input logic [1:0] ty, input bit rk,
                      input bit e, input string t);
    @(posedge clk); #1;
    cmd_valid = v; cmd_type = ty; cmd_rank = rk;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      cmd_valid = 1'b0; cmd_type = 2'b11;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(0, 2'b01, 0, 0, "R1 reset idle");
    step(1, 2'b11, 0, 1, "R1 free type");
    // R2 fresh history, R3 same type same rank
    step(1, 2'b01, 0, 1, "R2 first read");
    step(1, 2'b01, 0, 0, "R3 gap1");
    idle(1);
    step(1, 2'b01, 0, 0, "R3 gap3");
    step(1, 2'b01, 0, 1, "R3 gap4");
    // R4 rank switch
    idle(3);
    step(1, 2'b01, 1, 0, "R4 gap4");
    step(1, 2'b01, 1, 1, "R4 gap5");
    // R5 read to write
    idle(5);
    step(1, 2'b10, 1, 0, "R5 gap6");
    step(1, 2'b10, 1, 1, "R5 gap7");
    // R6 write to read same rank
    idle(14);
    step(1, 2'b01, 1, 0, "R6 gap15");
    step(1, 2'b01, 1, 1, "R6 gap16");
    // R7 write to read other rank
    idle(6);
    step(1, 2'b10, 0, 1, "R5 wr other rank gap7");
    idle(2);
    step(1, 2'b01, 1, 0, "R7 gap3");
    step(1, 2'b01, 1, 1, "R7 gap4");
    // R10 activates and free types do not touch column history
    step(1, 2'b00, 0, 1, "R10 act between reads");
    step(1, 2'b11, 1, 1, "R10 free between reads");
    step(1, 2'b01, 1, 0, "R10 blocked read gap3");
    step(1, 2'b01, 1, 1, "R10 read gap4");
    // R8 / R9 four activate window
    idle(30);
    step(1, 2'b00, 0, 1, "R8 act1");
    step(1, 2'b00, 0, 1, "R8 act2");
    step(1, 2'b00, 0, 1, "R8 act3");
    step(1, 2'b00, 0, 1, "R8 act4");
    step(1, 2'b00, 0, 0, "R8 act5 blocked");
    step(1, 2'b00, 1, 1, "R9 other rank act");
    idle(13);
    step(1, 2'b00, 0, 0, "R8 act at 19");
    step(1, 2'b00, 0, 1, "R8 act at 20");
    // R11 saturation
    idle(300);
    step(0, 2'b10, 1, 0, "R1 invalid write");
    step(1, 2'b10, 1, 1, "R11 after long idle");
    step(1, 2'b10, 1, 0, "R3 after saturation gap1");
    idle(2);
    done = 1;
  end

  initial begin
    while (!done && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: done=0 expected=1");
    end
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule